// File: doc/BRIEF.md
# ADC Conversion Start and Result Formatting Controller

This block holds the small control register set for an on-chip analog-to-digital converter and decides in which cycle a conversion begins. Six event flags from neighbouring peripherals feed a three-bit source selector; when auto-triggering is on, a rising edge of the *selected* flag (not of any raw event) yields a single-cycle start pulse towards the conversion sequencer. A free-running mode restarts the converter one cycle after every completion, and software may also request a single conversion directly.

The sequencer is seen only through a busy level, a one-cycle done pulse and the 10-bit result that accompanies it. The result has no back-pressure: it is valid only in the cycle of the done pulse and is captured then, unconditionally. Reads return it as two bytes, right or left justified, and the block also returns the digital pin levels with pins marked analog forced to zero.

Register map (8-bit data, 3-bit address): 0 control, 1 trigger select, 2 analog-pin mask, 3 result low byte, 4 result high byte, 5 gated pin levels, 6 and 7 read as zero. Control bits: bit0 converter enable, bit1 auto-trigger enable, bit2 left-justify, bit3 start strobe (write only, reads 0), bit4 completion flag (set by the done pulse, cleared by writing 1), bits 7:5 read 0. Reads are combinational from the read address.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset every register reads 0 (with pin inputs at 0) and `conv_start` is 0.
- R2: Select code k (1 to 6) picks `evt_flags[k-1]`; with enable and auto-trigger set, a 0-to-1 change of the picked flag gives `conv_start` high in the cycle after the clock edge that first samples it, for exactly one cycle; flags that are not picked give no pulse.
- R3: A flag held at 1 gives only one pulse; the level itself never requests a conversion.
- R4: Changing the select code from a source whose flag is 0 to one whose flag is 1 gives one start pulse; changing between two set flags gives none.
- R5: Code 0 (free running) and code 7 (reserved) act as a constant-0 trigger: switching to them never gives a pulse, even with all flags and the completion flag at 1.
- R6: With auto-trigger enable at 0, flag edges and the select code have no effect on `conv_start`.
- R7: `conv_start` is only issued while the enable bit is 1.
- R8: With enable and auto-trigger at 1 and code 0, each `conv_done` pulse gives `conv_start` high in the following cycle.
- R9: A trigger edge or start strobe seen while `conv_busy` is 1 is dropped and is not replayed when busy falls.
- R10: Writing 1 to control bit3 while already enabled and not busy gives one start pulse in the cycle after the write edge.
- R11: With bit2 at 0 the result reads low = r[7:0], high = r[9:8] in bits 1:0; with bit2 at 1, high = r[9:2] and low = r[1:0] in bits 7:6, other bits 0.
- R12: Address 1 reads bits 7:3 as 0; control bits 7:5 and 3 read 0; control bit4 is set by `conv_done` and cleared by writing it with 1.
- R13: Address 5 returns `pin_in[i]` in bit i unless mask bit i (address 2) is 1, in which case bit i reads 0; bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| evt_flags | input | 6 | Peripheral event flags, index = select code minus 1 |
| pin_in | input | 6 | Digital pin levels |
| conv_busy | input | 1 | Sequencer is converting |
| conv_done | input | 1 | One-cycle completion pulse, result valid |
| conv_result | input | 10 | Conversion result, sampled with `conv_done` |
| conv_start | output | 1 | One-cycle conversion start pulse |

## Verification
The hardest situation to reach is an edge created by the selector itself rather than by a flag: the stimulus parks a set flag on an unselected source, then rewrites the select code and counts pulses, and repeats the switch towards codes 0 and 7 after forcing every flag and the completion flag to 1. Every select code is swept against every flag, all 1024 result values are passed through both justifications, and all 64 mask values are crossed with all 64 pin patterns.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    ADDR_CTRL = 3'd0,
    ADDR_TSEL = 3'd1,
    ADDR_AMSK = 3'd2,
    ADDR_RLO  = 3'd3,
    ADDR_RHI  = 3'd4,
    ADDR_PINS = 3'd5
  } reg_addr_e;

  localparam int CB_EN   = 0;
  localparam int CB_AUTO = 1;
  localparam int CB_LADJ = 2;
  localparam int CB_GO   = 3;
  localparam int CB_DONE = 4;

  typedef struct packed {
    logic done;
    logic ladj;
    logic auto_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/trig_select.sv
module trig_select #(
  parameter int N_EVT = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_EVT-1:0] evt_flags,
  output logic             trig_edge
);
  localparam int N_CODE = 1 << SEL_W;

  logic [N_CODE-1:0] cand;
  logic              sel_level;
  logic              level_q;

  // code 0 (free running) and any code beyond the event count are constant 0
  for (genvar c = 0; c < N_CODE; c++) begin : g_cand
    if (c >= 1 && c <= N_EVT) begin : g_src
      assign cand[c] = evt_flags[c-1];
    end else begin : g_zero
      assign cand[c] = 1'b0;
    end
  end

  assign sel_level = cand[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= sel_level;
  end

  assign trig_edge = sel_level & ~level_q;
endmodule

// File: rtl/start_ctrl.sv
module start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic auto_en,
  input  logic free_run,
  input  logic trig_edge,
  input  logic go,
  input  logic conv_busy,
  input  logic conv_done,
  output logic conv_start
);
  logic edge_req, fr_req, go_req, any_req;

  always_comb begin
    edge_req = auto_en & trig_edge & ~conv_busy;
    fr_req   = auto_en & free_run & conv_done;
    go_req   = go & ~conv_busy;
    any_req  = edge_req | fr_req | go_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) conv_start <= 1'b0;
    else        conv_start <= en & ~conv_start & any_req;
  end
endmodule

// File: rtl/result_fmt.sv
module result_fmt #(
  parameter int RES_W = 10,
  parameter int DW    = 8
) (
  input  logic [RES_W-1:0] res,
  input  logic             ladj,
  output logic [DW-1:0]    lo_byte,
  output logic [DW-1:0]    hi_byte
);
  localparam int PAD = 2*DW - RES_W;

  logic [2*DW-1:0] wide;

  if (PAD > 0) begin : g_pad
    always_comb begin
      if (ladj) wide = {res, {PAD{1'b0}}};
      else      wide = {{PAD{1'b0}}, res};
    end
  end else begin : g_nopad
    assign wide = res;
  end

  assign lo_byte = wide[DW-1:0];
  assign hi_byte = wide[2*DW-1:DW];
endmodule

// File: rtl/pin_gate.sv
module pin_gate #(
  parameter int N_PINS = 6
) (
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] amask,
  output logic [N_PINS-1:0] pin_rd
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pin_rd[i] = pin_in[i] & ~amask[i];
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int N_EVT  = 6,
  parameter int SEL_W  = 3,
  parameter int RES_W  = 10,
  parameter int N_PINS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [N_EVT-1:0]  evt_flags,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              conv_busy,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              conv_start
);
  ctrl_t             ctrl_q;
  logic [SEL_W-1:0]  sel_q;
  logic [N_PINS-1:0] amask_q;
  logic [RES_W-1:0]  res_q;

  logic wr_ctrl, wr_tsel, wr_amsk;
  logic go, trig_edge, free_run;
  logic [REG_DW-1:0] lo_byte, hi_byte;
  logic [N_PINS-1:0] pin_rd;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_waddr == ADDR_CTRL);
    wr_tsel  = reg_wr && (reg_waddr == ADDR_TSEL);
    wr_amsk  = reg_wr && (reg_waddr == ADDR_AMSK);
    go       = wr_ctrl && reg_wdata[CB_GO];
    free_run = (sel_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sel_q   <= '0;
      amask_q <= '0;
      res_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en      <= reg_wdata[CB_EN];
        ctrl_q.auto_en <= reg_wdata[CB_AUTO];
        ctrl_q.ladj    <= reg_wdata[CB_LADJ];
      end
      if (conv_done)                          ctrl_q.done <= 1'b1;
      else if (wr_ctrl && reg_wdata[CB_DONE]) ctrl_q.done <= 1'b0;
      if (wr_tsel) sel_q   <= reg_wdata[SEL_W-1:0];
      if (wr_amsk) amask_q <= reg_wdata[N_PINS-1:0];
      if (conv_done) res_q <= conv_result;
    end
  end

  trig_select #(.N_EVT(N_EVT), .SEL_W(SEL_W)) u_tsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel_q),
    .evt_flags (evt_flags),
    .trig_edge (trig_edge)
  );

  start_ctrl u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctrl_q.en),
    .auto_en    (ctrl_q.auto_en),
    .free_run   (free_run),
    .trig_edge  (trig_edge),
    .go         (go),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .conv_start (conv_start)
  );

  result_fmt #(.RES_W(RES_W), .DW(REG_DW)) u_fmt (
    .res     (res_q),
    .ladj    (ctrl_q.ladj),
    .lo_byte (lo_byte),
    .hi_byte (hi_byte)
  );

  pin_gate #(.N_PINS(N_PINS)) u_pins (
    .pin_in (pin_in),
    .amask  (amask_q),
    .pin_rd (pin_rd)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      ADDR_CTRL: begin
        reg_rdata[CB_EN]   = ctrl_q.en;
        reg_rdata[CB_AUTO] = ctrl_q.auto_en;
        reg_rdata[CB_LADJ] = ctrl_q.ladj;
        reg_rdata[CB_DONE] = ctrl_q.done;
      end
      ADDR_TSEL: reg_rdata[SEL_W-1:0]  = sel_q;
      ADDR_AMSK: reg_rdata[N_PINS-1:0] = amask_q;
      ADDR_RLO:  reg_rdata = lo_byte;
      ADDR_RHI:  reg_rdata = hi_byte;
      ADDR_PINS: reg_rdata[N_PINS-1:0] = pin_rd;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk #(
  parameter int SEL_W  = 3,
  parameter int RES_W  = 10,
  parameter int N_PINS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_waddr,
  input logic [7:0]        reg_wdata,
  input logic [2:0]        reg_raddr,
  input logic [7:0]        reg_rdata,
  input logic              conv_busy,
  input logic              conv_done,
  input logic              conv_start,
  input logic              en_q,
  input logic              auto_q,
  input logic              ladj_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic [N_PINS-1:0] amask_q
);
  localparam int PAD = 16 - RES_W;
  localparam logic [7:0] LO_MASK = 8'((1 << PAD) - 1);

  // R2 R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R7
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(en_q));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(conv_busy));

  // R5 R6
  quiet_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(!auto_q || sel_q == '1))
      |-> $past(reg_wr && reg_waddr == 3'd0 && reg_wdata[3]));

  // R8
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(conv_done && en_q && auto_q && sel_q == '0) && !$past(conv_start))
      |-> conv_start);

  // R12
  tsel_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr == 3'd1) |-> (reg_rdata[7:SEL_W] == '0));

  // R11
  left_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr == 3'd3 && ladj_q) |-> ((reg_rdata & LO_MASK) == 8'd0));

  // R13
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr == 3'd5) |-> ((reg_rdata[N_PINS-1:0] & amask_q) == '0));
endmodule

bind adc_trig_ctrl adc_trig_chk #(.SEL_W(SEL_W), .RES_W(RES_W), .N_PINS(N_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_waddr  (reg_waddr),
  .reg_wdata  (reg_wdata),
  .reg_raddr  (reg_raddr),
  .reg_rdata  (reg_rdata),
  .conv_busy  (conv_busy),
  .conv_done  (conv_done),
  .conv_start (conv_start),
  .en_q       (ctrl_q.en),
  .auto_q     (ctrl_q.auto_en),
  .ladj_q     (ctrl_q.ladj),
  .sel_q      (sel_q),
  .amask_q    (amask_q)
);

// File: tb/test_adc_trig_ctrl.sv
`timescale 1ns/1ps
module test_adc_trig_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_waddr = '0;
  logic [7:0] reg_wdata = '0;
  logic [2:0] reg_raddr = '0;
  logic [7:0] reg_rdata;
  logic [5:0] evt_flags = '0;
  logic [5:0] pin_in = '0;
  logic       conv_busy = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = '0;
  logic       conv_start;

  int n_tests = 0;
  int n_fail  = 0;
  int starts  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_trig_ctrl i_adc_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .evt_flags(evt_flags), .pin_in(pin_in), .conv_busy(conv_busy),
    .conv_done(conv_done), .conv_result(conv_result), .conv_start(conv_start)
  );

  always @(posedge clk) begin
    #1;
    if (rst_n && conv_start) starts++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic done_pulse(input logic [9:0] r);
    @(negedge clk);
    conv_result = r; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, lo, hi;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset read", d, 0);
    end
    chk("R1 reset start", conv_start, 0);

    // R2 R3 R5 sweep every select code against every flag
    wr(3'd0, 8'h03);
    for (int code = 0; code < 8; code++) begin
      wr(3'd1, 8'(code));
      for (int j = 0; j < 6; j++) begin
        evt_flags = '0;
        idle(2);
        starts = 0;
        evt_flags[j] = 1'b1;
        idle(6);
        chk($sformatf("R2 R3 code%0d flag%0d", code, j), starts,
            (code >= 1 && code <= 6 && j == code - 1) ? 1 : 0);
      end
    end
    evt_flags = '0;

    // R2 exact cycle of the start pulse
    wr(3'd1, 8'd3);
    idle(2);
    evt_flags[2] = 1'b1;
    @(negedge clk);
    chk("R2 pulse cycle", conv_start, 1);
    @(negedge clk);
    chk("R2 pulse width", conv_start, 0);
    evt_flags = '0;
    idle(2);

    // R4 selection change creates edge
    wr(3'd1, 8'd2);
    evt_flags[3] = 1'b1;
    idle(3);
    starts = 0;
    wr(3'd1, 8'd4);
    idle(3);
    chk("R4 clear-to-set switch", starts, 1);
    evt_flags[4] = 1'b1;
    idle(3);
    starts = 0;
    wr(3'd1, 8'd5);
    idle(3);
    chk("R4 set-to-set switch", starts, 0);

    // R5 switching to code 0 or 7 with everything set
    evt_flags = 6'h3F;
    done_pulse(10'd0);
    idle(3);
    rd(3'd0, d);
    chk("R5 done flag set", d[4], 1);
    starts = 0;
    wr(3'd1, 8'd0);
    idle(4);
    chk("R5 switch to free run", starts, 0);
    wr(3'd1, 8'd6);
    idle(3);
    starts = 0;
    wr(3'd1, 8'd7);
    idle(4);
    chk("R5 switch to reserved", starts, 0);
    evt_flags = '0;
    idle(2);

    // R6 auto-trigger off
    wr(3'd0, 8'h01);
    wr(3'd1, 8'd1);
    idle(2);
    starts = 0;
    evt_flags[0] = 1'b1;
    idle(4);
    chk("R6 auto off", starts, 0);
    evt_flags = '0;
    wr(3'd1, 8'd0);
    done_pulse(10'd5);
    idle(3);
    chk("R6 auto off free run", starts, 0);

    // R7 enable off
    wr(3'd0, 8'h02);
    wr(3'd1, 8'd1);
    idle(2);
    starts = 0;
    evt_flags[0] = 1'b1;
    idle(4);
    chk("R7 enable off edge", starts, 0);
    evt_flags = '0;
    wr(3'd1, 8'd0);
    done_pulse(10'd7);
    idle(3);
    chk("R7 enable off free run", starts, 0);

    // R8 free running
    wr(3'd0, 8'h03);
    wr(3'd1, 8'd0);
    idle(2);
    starts = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      chk("R8 restart cycle", conv_start, 1);
      idle(3);
    end
    chk("R8 restart count", starts, 3);

    // R9 edge while busy
    wr(3'd1, 8'd1);
    idle(2);
    starts = 0;
    conv_busy = 1'b1;
    evt_flags[0] = 1'b1;
    idle(3);
    conv_busy = 1'b0;
    idle(4);
    chk("R9 edge while busy", starts, 0);
    evt_flags = '0;
    idle(2);

    // R10 start strobe
    wr(3'd0, 8'h00);
    idle(2);
    starts = 0;
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 3'd0; reg_wdata = 8'h08;
    @(negedge clk);
    reg_wr = 1'b0;
    idle(3);
    chk("R10 strobe when disabled", starts, 0);
    wr(3'd0, 8'h01);
    starts = 0;
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 3'd0; reg_wdata = 8'h09;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 strobe cycle", conv_start, 1);
    idle(3);
    chk("R10 strobe count", starts, 1);
    starts = 0;
    conv_busy = 1'b1;
    wr(3'd0, 8'h09);
    idle(3);
    conv_busy = 1'b0;
    idle(2);
    chk("R9 strobe while busy", starts, 0);

    // R11 result justification, all values
    for (int la = 0; la < 2; la++) begin
      wr(3'd0, la ? 8'h04 : 8'h00);
      for (int r = 0; r < 1024; r++) begin
        done_pulse(10'(r));
        rd(3'd3, lo);
        rd(3'd4, hi);
        if (la == 0) begin
          chk("R11 right lo", lo, r & 255);
          chk("R11 right hi", hi, r >> 8);
        end else begin
          chk("R11 left lo", lo, (r & 3) << 6);
          chk("R11 left hi", hi, r >> 2);
        end
      end
    end

    // R12 reserved bits and completion flag
    rd(3'd0, d);
    chk("R12 ctrl with done", d, 8'h14);
    wr(3'd0, 8'hF7);
    rd(3'd0, d);
    chk("R12 ctrl reserved and clear", d, 8'h07);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, d);
    chk("R12 select reserved", d, 8'h07);
    wr(3'd1, 8'h00);
    rd(3'd6, d);
    chk("R12 addr6", d, 0);
    rd(3'd7, d);
    chk("R12 addr7", d, 0);

    // R13 pin gating sweep
    for (int m = 0; m < 64; m++) begin
      wr(3'd2, 8'(m));
      rd(3'd2, d);
      chk("R13 mask readback", d, m);
      for (int p = 0; p < 64; p++) begin
        pin_in = 6'(p);
        rd(3'd5, d);
        chk("R13 gated pins", d, p & ~m & 63);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule